// File: doc/BRIEF.md
# DAC Code Format Converter

This block turns one signed output code for a two-stage multiplying DAC into the pair of control bytes that program the stages. The upper stage takes the five most significant magnitude bits and the lower stage takes the two least significant ones. Each stage byte carries a sign bit, and the lower stage uses the opposite sign sense to the upper. The caller can present the code in one of three forms, chosen per strobe by a 2-bit select: offset binary, two's complement, or an already packed pair of sign-and-magnitude bytes.

Every form is reduced to one sign and a 7-bit magnitude. Codes just outside the legal span are clamped to the nearest legal extreme. Malformed packed pairs are decoded anyway. In both cases an out-of-range flag is raised alongside the result. Both stage bytes are registered and move together, one clock after the strobe, so a downstream register writer never sees a half-updated pair.

Top module: `dacfmt_conv`

## Requirements
- R1: After reset the upper byte is 0x80, the lower byte is 0xA0, and both `out_valid` and `out_of_range` are 0. This is the midscale state: zero magnitude, upper sign 0, lower sign 1.
- R2: A strobe (`in_valid`=1 with a legal format) at a rising edge updates both bytes on that edge. `out_valid` is then 1 for exactly the following cycle. With no strobe, both bytes hold and `out_valid` is 0.
- R3: In both bytes, bit 7 is 1 and bit 6 is 0. Bits 2..0 of the lower byte are always 0.
- R4: Upper byte bit 5 is the sign (1 = negative), and bits 4..0 are magnitude bits 6..2. Lower byte bit 5 is the inverted sign (1 = positive), and bits 4..3 are magnitude bits 1..0.
- R5: With `fmt_sel`=2'b00 (offset binary), `code_in` 0..254 stands for the value `code_in` − 127.
- R6: With `fmt_sel`=2'b01 (two's complement), `code_in` is a signed byte in −127..+127.
- R7: With `fmt_sel`=2'b10 (packed), the upper input byte has the form 00smmmmm and the lower input byte has the form 00tmm000, with t = not s. The magnitude is the upper byte's bits 4..0 followed by the lower byte's bits 4..3, and the sign is the upper byte's bit 5. 0x3F/0x18 is −127 and 0x1F/0x38 is +127. `code_in` is ignored in this format; the packed bytes are ignored in the other formats.
- R8: Offset binary 255 is clamped to +127, and two's complement 0x80 is clamped to −127. In both cases `out_of_range` is 1 during the output cycle of that strobe.
- R9: A packed pair with nonzero bits 7..6 in either byte, nonzero lower bits 2..0, or t equal to s sets `out_of_range`. The fields are still decoded as in R7.
- R10: `fmt_sel`=2'b11 is reserved. A strobe carrying it gives no `out_valid` and leaves both bytes unchanged.
- R11: A zero magnitude always produces the positive sign, including a packed negative zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| fmt_sel | input | 2 | Format: 00 offset binary, 01 two's complement, 10 packed, 11 reserved |
| code_in | input | 8 | Single-byte code |
| pk_hi_in | input | 8 | Packed upper byte |
| pk_lo_in | input | 8 | Packed lower byte |
| hi_cr_out | output | 8 | Upper-stage control byte |
| lo_cr_out | output | 8 | Lower-stage control byte |
| out_valid | output | 1 | New bytes present this cycle |
| out_of_range | output | 1 | Clamp or malformed packed input for the current result |

## Verification
Clamping and the output update land in the same cycle. The flag and the clamped bytes must appear together on the one `out_valid` cycle, and the flag must fall on the next strobe.

Back-to-back strobes provoke this: a clamped code (offset binary 255) is followed directly by a legal two's complement code. The bench then expects `out_valid` high in both cycles, the flag high only in the first, and the bytes to move from 0x9F/0xB8 to the new value with no idle cycle between.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;

    // Format select encoding
    typedef enum logic [1:0] {
        FMT_OFFBIN = 2'b00,
        FMT_TWOS   = 2'b01,
        FMT_PACKED = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    // Fixed top bits of every stage control byte
    localparam logic [1:0] CR_FIXED_TOP = 2'b10;

endpackage

// File: rtl/dacfmt_numdec.sv
// Decodes a single-byte numeric code (offset binary or two's complement,
// chosen by TWOS) to sign and magnitude, clamping the one illegal code.
module dacfmt_numdec #(
    parameter int CODE_W = 8,
    parameter bit TWOS   = 1'b0
) (
    input  logic [CODE_W-1:0] code,
    output logic              neg,
    output logic [CODE_W-2:0] mag,
    output logic              clamp
);
    localparam int MAG_W = CODE_W - 1;
    localparam logic [CODE_W-1:0] BIAS    = {1'b0, {MAG_W{1'b1}}};
    localparam logic [CODE_W-1:0] OB_BAD  = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] TC_BAD  = {1'b1, {MAG_W{1'b0}}};

    generate
        if (TWOS) begin : g_twos
            always_comb begin
                neg   = code[CODE_W-1];
                clamp = 1'b0;
                if (code == TC_BAD) begin
                    mag   = {MAG_W{1'b1}};
                    clamp = 1'b1;
                end else if (code[CODE_W-1]) begin
                    mag = MAG_W'(~code[MAG_W-1:0] + 1'b1);
                end else begin
                    mag = code[MAG_W-1:0];
                end
            end
        end else begin : g_offbin
            always_comb begin
                neg   = 1'b0;
                clamp = 1'b0;
                if (code == OB_BAD) begin
                    mag   = {MAG_W{1'b1}};
                    clamp = 1'b1;
                end else if (code >= BIAS) begin
                    mag = MAG_W'(code - BIAS);
                end else begin
                    neg = 1'b1;
                    mag = MAG_W'(BIAS - code);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dacfmt_unpack.sv
// Extracts sign and magnitude from a packed byte pair and flags malformed pairs.
module dacfmt_unpack #(
    parameter int HI_MAG_W = 5,
    parameter int LO_MAG_W = 2
) (
    input  logic [HI_MAG_W+2:0]          pk_hi,
    input  logic [HI_MAG_W+2:0]          pk_lo,
    output logic                         neg,
    output logic [HI_MAG_W+LO_MAG_W-1:0] mag,
    output logic                         bad
);
    localparam int BYTE_W = HI_MAG_W + 3;
    localparam int SGN    = HI_MAG_W;
    localparam int PAD_W  = HI_MAG_W - LO_MAG_W;

    logic top_junk;
    logic pad_junk;
    logic sign_clash;

    assign neg        = pk_hi[SGN];
    assign mag        = {pk_hi[HI_MAG_W-1:0], pk_lo[HI_MAG_W-1 -: LO_MAG_W]};
    assign top_junk   = (|pk_hi[BYTE_W-1:SGN+1]) | (|pk_lo[BYTE_W-1:SGN+1]);
    assign pad_junk   = |pk_lo[PAD_W-1:0];
    assign sign_clash = (pk_lo[SGN] == pk_hi[SGN]);
    assign bad        = top_junk | pad_junk | sign_clash;

endmodule

// File: rtl/dacfmt_pack.sv
// Builds the two stage control bytes from sign and magnitude.
module dacfmt_pack
    import dacfmt_pkg::*;
#(
    parameter int HI_MAG_W = 5,
    parameter int LO_MAG_W = 2
) (
    input  logic                         neg,
    input  logic [HI_MAG_W+LO_MAG_W-1:0] mag,
    output logic [HI_MAG_W+2:0]          hi_cr,
    output logic [HI_MAG_W+2:0]          lo_cr
);
    localparam int MAG_W = HI_MAG_W + LO_MAG_W;
    localparam int PAD_W = HI_MAG_W - LO_MAG_W;

    assign hi_cr = {CR_FIXED_TOP, neg, mag[MAG_W-1 -: HI_MAG_W]};
    assign lo_cr = {CR_FIXED_TOP, ~neg, mag[LO_MAG_W-1:0], {PAD_W{1'b0}}};

endmodule

// File: rtl/dacfmt_conv.sv
module dacfmt_conv
    import dacfmt_pkg::*;
#(
    parameter int HI_MAG_W = 5,
    parameter int LO_MAG_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           fmt_sel,
    input  logic [HI_MAG_W+2:0]  code_in,
    input  logic [HI_MAG_W+2:0]  pk_hi_in,
    input  logic [HI_MAG_W+2:0]  pk_lo_in,
    output logic [HI_MAG_W+2:0]  hi_cr_out,
    output logic [HI_MAG_W+2:0]  lo_cr_out,
    output logic                 out_valid,
    output logic                 out_of_range
);
    localparam int MAG_W  = HI_MAG_W + LO_MAG_W;
    localparam int CODE_W = MAG_W + 1;
    localparam int BYTE_W = HI_MAG_W + 3;

    localparam logic [BYTE_W-1:0] RST_HI = {CR_FIXED_TOP, 1'b0, {HI_MAG_W{1'b0}}};
    localparam logic [BYTE_W-1:0] RST_LO = {CR_FIXED_TOP, 1'b1, {HI_MAG_W{1'b0}}};

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              vld;
        logic              oor;
    } conv_st_t;

    // Decoder outputs per format
    logic             ob_neg, tc_neg, pk_neg;
    logic [MAG_W-1:0] ob_mag, tc_mag, pk_mag;
    logic             ob_clamp, tc_clamp, pk_bad;

    dacfmt_numdec #(.CODE_W(CODE_W), .TWOS(1'b0)) u_ob (
        .code  (code_in),
        .neg   (ob_neg),
        .mag   (ob_mag),
        .clamp (ob_clamp)
    );

    dacfmt_numdec #(.CODE_W(CODE_W), .TWOS(1'b1)) u_tc (
        .code  (code_in),
        .neg   (tc_neg),
        .mag   (tc_mag),
        .clamp (tc_clamp)
    );

    dacfmt_unpack #(.HI_MAG_W(HI_MAG_W), .LO_MAG_W(LO_MAG_W)) u_unpk (
        .pk_hi (pk_hi_in),
        .pk_lo (pk_lo_in),
        .neg   (pk_neg),
        .mag   (pk_mag),
        .bad   (pk_bad)
    );

    // Format selection and zero normalisation
    logic             sel_neg_raw;
    logic             sel_neg;
    logic [MAG_W-1:0] sel_mag;
    logic             sel_oor;
    logic             fmt_ok;

    always_comb begin
        sel_neg_raw = 1'b0;
        sel_mag     = '0;
        sel_oor     = 1'b0;
        fmt_ok      = 1'b1;
        case (fmt_e'(fmt_sel))
            FMT_OFFBIN: begin
                sel_neg_raw = ob_neg;
                sel_mag     = ob_mag;
                sel_oor     = ob_clamp;
            end
            FMT_TWOS: begin
                sel_neg_raw = tc_neg;
                sel_mag     = tc_mag;
                sel_oor     = tc_clamp;
            end
            FMT_PACKED: begin
                sel_neg_raw = pk_neg;
                sel_mag     = pk_mag;
                sel_oor     = pk_bad;
            end
            default: fmt_ok = 1'b0;
        endcase
        sel_neg = sel_neg_raw & (|sel_mag);
    end

    logic [BYTE_W-1:0] hi_nx, lo_nx;

    dacfmt_pack #(.HI_MAG_W(HI_MAG_W), .LO_MAG_W(LO_MAG_W)) u_pack (
        .neg   (sel_neg),
        .mag   (sel_mag),
        .hi_cr (hi_nx),
        .lo_cr (lo_nx)
    );

    conv_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.oor = 1'b0;
        if (in_valid && fmt_ok) begin
            st_d.hi  = hi_nx;
            st_d.lo  = lo_nx;
            st_d.vld = 1'b1;
            st_d.oor = sel_oor;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hi: RST_HI, lo: RST_LO, vld: 1'b0, oor: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_cr_out    = st_q.hi;
    assign lo_cr_out    = st_q.lo;
    assign out_valid    = st_q.vld;
    assign out_of_range = st_q.oor;

endmodule

// File: rtl/dacfmt_conv_chk.sv
module dacfmt_conv_chk #(
    parameter int HI_MAG_W = 5,
    parameter int LO_MAG_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          fmt_sel,
    input logic [HI_MAG_W+2:0] hi_cr_out,
    input logic [HI_MAG_W+2:0] lo_cr_out,
    input logic                out_valid,
    input logic                out_of_range
);
    localparam int BYTE_W = HI_MAG_W + 3;
    localparam int PAD_W  = HI_MAG_W - LO_MAG_W;

    logic strobe;
    assign strobe = in_valid && (fmt_sel != 2'b11);

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cr_out[BYTE_W-1 -: 2] == 2'b10 && lo_cr_out[BYTE_W-1 -: 2] == 2'b10
        && lo_cr_out[PAD_W-1:0] == '0);                                      // R3

    AST_SIGN_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cr_out[HI_MAG_W] != lo_cr_out[HI_MAG_W]);                         // R4

    AST_STROBE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> out_valid);                                               // R2

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !out_valid);                                             // R10

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(hi_cr_out) && $stable(lo_cr_out)));          // R2

    AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> out_valid);                                         // R8

    AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cr_out[HI_MAG_W-1:0] == '0 && lo_cr_out[HI_MAG_W-1 -: LO_MAG_W] == '0)
        |-> !hi_cr_out[HI_MAG_W]);                                           // R11

endmodule

bind dacfmt_conv dacfmt_conv_chk #(.HI_MAG_W(HI_MAG_W), .LO_MAG_W(LO_MAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .fmt_sel      (fmt_sel),
    .hi_cr_out    (hi_cr_out),
    .lo_cr_out    (lo_cr_out),
    .out_valid    (out_valid),
    .out_of_range (out_of_range)
);

// File: tb/tb_dacfmt_conv.sv
`timescale 1ns/1ps
module tb_dacfmt_conv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] fmt_sel = 2'b00;
    logic [7:0] code_in = 8'h00;
    logic [7:0] pk_hi_in = 8'h00;
    logic [7:0] pk_lo_in = 8'h00;
    logic [7:0] hi_cr_out, lo_cr_out;
    logic       out_valid, out_of_range;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dacfmt_conv dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .fmt_sel      (fmt_sel),
        .code_in      (code_in),
        .pk_hi_in     (pk_hi_in),
        .pk_lo_in     (pk_lo_in),
        .hi_cr_out    (hi_cr_out),
        .lo_cr_out    (lo_cr_out),
        .out_valid    (out_valid),
        .out_of_range (out_of_range)
    );

    // {fmt, code, pk_hi, pk_lo, exp_hi, exp_lo, exp_oor}
    localparam int NV = 19;
    localparam logic [42:0] VEC [0:NV-1] = '{
        {2'b00, 8'h7F, 8'hFF, 8'hFF, 8'h80, 8'hA0, 1'b0},
        {2'b00, 8'hFE, 8'hFF, 8'hFF, 8'h9F, 8'hB8, 1'b0},
        {2'b00, 8'h00, 8'hFF, 8'hFF, 8'hBF, 8'h98, 1'b0},
        {2'b00, 8'h80, 8'hFF, 8'hFF, 8'h80, 8'hA8, 1'b0},
        {2'b00, 8'h64, 8'hFF, 8'hFF, 8'hA6, 8'h98, 1'b0},
        {2'b01, 8'h00, 8'hFF, 8'hFF, 8'h80, 8'hA0, 1'b0},
        {2'b01, 8'h7F, 8'hFF, 8'hFF, 8'h9F, 8'hB8, 1'b0},
        {2'b01, 8'h81, 8'hFF, 8'hFF, 8'hBF, 8'h98, 1'b0},
        {2'b01, 8'hFF, 8'hFF, 8'hFF, 8'hA0, 8'h88, 1'b0},
        {2'b01, 8'h2A, 8'hFF, 8'hFF, 8'h8A, 8'hB0, 1'b0},
        {2'b10, 8'h55, 8'h3F, 8'h18, 8'hBF, 8'h98, 1'b0},
        {2'b10, 8'h55, 8'h1F, 8'h38, 8'h9F, 8'hB8, 1'b0},
        {2'b10, 8'h55, 8'h05, 8'h30, 8'h85, 8'hB0, 1'b0},
        {2'b10, 8'h55, 8'h20, 8'h00, 8'h80, 8'hA0, 1'b0},
        {2'b00, 8'hFF, 8'h00, 8'h00, 8'h9F, 8'hB8, 1'b1},
        {2'b01, 8'h80, 8'h00, 8'h00, 8'hBF, 8'h98, 1'b1},
        {2'b10, 8'h55, 8'h01, 8'h08, 8'h81, 8'hA8, 1'b1},
        {2'b10, 8'h55, 8'h00, 8'h21, 8'h80, 8'hA0, 1'b1},
        {2'b10, 8'h55, 8'h42, 8'h20, 8'h82, 8'hA0, 1'b1}
    };

    function automatic string vec_req(int i);
        if (i < 5)  return "R5";
        if (i < 10) return "R6";
        if (i < 13) return "R7";
        if (i == 13) return "R11";
        if (i < 16) return "R8";
        return "R9";
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] f, input logic [7:0] c,
                         input logic [7:0] h, input logic [7:0] l);
        fmt_sel  = f;
        code_in  = c;
        pk_hi_in = h;
        pk_lo_in = l;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "hi", hi_cr_out, 8'h80);
        chk("R1", "lo", lo_cr_out, 8'hA0);
        chk("R1", "valid", out_valid, 0);
        chk("R1", "oor", out_of_range, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [42:0] v;
            v = VEC[i];
            drive(v[42:41], v[40:33], v[32:25], v[24:17]);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R2", "valid", out_valid, 1);
            chk(vec_req(i), "hi", hi_cr_out, v[16:9]);
            chk(vec_req(i), "lo", lo_cr_out, v[8:1]);
            chk(vec_req(i), "oor", out_of_range, v[0]);
            chk("R3", "fixed", {hi_cr_out[7:6], lo_cr_out[7:6], lo_cr_out[2:0]}, 7'b1010000);
            chk("R4", "sign", hi_cr_out[5] ^ lo_cr_out[5], 1);
            @(negedge clk);
            chk("R2", "pulse", out_valid, 0);
            chk("R2", "hold", {hi_cr_out, lo_cr_out}, {v[16:9], v[8:1]});
        end

        // Back-to-back: clamp then legal (R8 flag and update in same cycle)
        drive(2'b00, 8'hFF, 8'h00, 8'h00);
        @(negedge clk);
        drive(2'b01, 8'h2A, 8'h00, 8'h00);
        chk("R8", "b2b valid1", out_valid, 1);
        chk("R8", "b2b oor1", out_of_range, 1);
        chk("R8", "b2b hi1", {hi_cr_out, lo_cr_out}, 16'h9FB8);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "b2b valid2", out_valid, 1);
        chk("R8", "b2b oor2", out_of_range, 0);
        chk("R6", "b2b bytes2", {hi_cr_out, lo_cr_out}, 16'h8AB0);

        // R10 reserved format ignored
        drive(2'b11, 8'h00, 8'h3F, 8'h18);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "valid", out_valid, 0);
        chk("R10", "bytes", {hi_cr_out, lo_cr_out}, 16'h8AB0);
        @(negedge clk);
        chk("R10", "bytes later", {hi_cr_out, lo_cr_out}, 16'h8AB0);

        // No strobe: hold (R2)
        code_in = 8'h00;
        fmt_sel = 2'b01;
        repeat (2) @(negedge clk);
        chk("R2", "idle hold", {hi_cr_out, lo_cr_out}, 16'h8AB0);

        // Mid-run reset returns to midscale (R1)
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "rerst bytes", {hi_cr_out, lo_cr_out}, 16'h80A0);
        chk("R1", "rerst valid", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule